// File: doc/BRIEF.md
# Discrete-Event Atomic Component Sequencer

This block is the control part of one atomic component in a hardware discrete-event simulator. The component sits in one of a small set of encoded states. Each state has a lifetime, held in a parameter table, that counts clock cycles. The all-ones lifetime code means infinite. When the lifetime runs out before any accepted input, the component becomes imminent. A central coordinator then runs each simulation step in two phases. In the speak phase, an imminent component emits its output event. In the move phase, it takes its internal transition.

Input events arrive as one strobe per port. A strobe on a port that the current state listens to is held as pending until the next move phase. At that point it selects an external transition from the state and the port. A strobe on any other port is dropped. Every move, of either kind, flushes all pending inputs and restarts the lifetime timer for the new state. All transition tables are parameters. No data values are computed here. The grants and acknowledges are single-cycle control pulses with no back-pressure: every grant is acknowledged exactly one cycle later, even when the component passes its turn.

Top module: `devs_atomic_seq`

## Requirements
- R1: While reset is asserted, cur_state is INIT_STATE and imminent, out_evt, spoke and moved are all 0.
- R2: For a finite, nonzero lifetime T, imminent rises on the T-th rising edge after the edge that entered the state. Leaving reset counts as entering INIT_STATE, so the count starts from the first edge with rst_n high.
- R3: A lifetime of 0 sets imminent on the same edge that enters the state.
- R4: A state whose lifetime is the all-ones code never becomes imminent and can only be left by an external transition.
- R5: spoke pulses one cycle after each spk_grant cycle. out_evt pulses with it only if imminent was 1 at the grant and no output has been emitted since the state was entered, so at most one output is emitted per stay.
- R6: moved pulses one cycle after each mv_grant cycle. If the component is imminent and has spoken at that grant, cur_state takes INT_NEXT entry (state) on that edge.
- R7: Every transition discards all pending inputs, so a following move grant with no new input leaves the state unchanged.
- R8: A strobe on port p while LISTEN bit (state*NP+p) is 1 stays pending. At the next move grant that is not taken by an internal transition, cur_state becomes EXT_NEXT entry (state*NP+p), imminent is cleared, and the old timer is cancelled. Among several pending ports, the lowest index wins.
- R9: A strobe on a port whose LISTEN bit is 0 is lost, and a later move grant is a pass.
- R10: When the component is imminent and has spoken, and an input is also pending at the move grant, INT_FIRST=1 takes the internal transition and INT_FIRST=0 takes the external one.
- R11: cur_state changes only on edges with mv_grant high, and imminent stays high until a move grant.
- R12: A move grant while imminent but not yet spoken does not take the internal transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_evt | input | NP | Input event strobe per port |
| spk_grant | input | 1 | Speak phase grant pulse |
| mv_grant | input | 1 | Move phase grant pulse |
| out_evt | output | 1 | Output event pulse |
| spoke | output | 1 | Speak phase acknowledge |
| moved | output | 1 | Move phase acknowledge |
| cur_state | output | SW | Current encoded state |
| imminent | output | 1 | Lifetime expired, awaiting internal transition |

## Verification
The internal and the external transition can both be due at the same move grant. This happens when a component that is imminent and has already spoken also holds an accepted input. The bench provokes it by emitting the output, strobing a listened port, and then granting the move. It runs this on two instances that differ only in INT_FIRST and judges the outcome by which table entry each cur_state reaches. It then grants another move to confirm that the losing input was flushed rather than kept.

// File: rtl/devs_seq_pkg.sv
package devs_seq_pkg;
  typedef enum logic [1:0] {
    ACT_PASS = 2'd0,
    ACT_INT  = 2'd1,
    ACT_EXT  = 2'd2
  } devs_act_e;
endpackage

// File: rtl/devs_life_timer.sv
module devs_life_timer #(
  parameter int TA_W = 6,
  parameter logic [TA_W-1:0] INIT_TA = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TA_W-1:0] load_ta,
  output logic            imm
);
  localparam logic [TA_W-1:0] TA_INF = '1;
  localparam logic [TA_W-1:0] TA_ONE = TA_W'(1);

  logic [TA_W-1:0] cnt_q;
  logic            run_q;

  // A new lifetime either arms the counter, sets imminent at once, or parks.
  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      automatic logic [TA_W-1:0] v = rst_n ? load_ta : INIT_TA;
      cnt_q <= v;
      run_q <= (v != TA_INF) && (v != '0);
      imm   <= (v == '0);
    end else if (run_q) begin
      cnt_q <= cnt_q - TA_ONE;
      if (cnt_q == TA_ONE) begin
        run_q <= 1'b0;
        imm   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/devs_port_latch.sv
module devs_port_latch #(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [NP-1:0] strobe,
  input  logic [NP-1:0] listen,
  output logic [NP-1:0] pend
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n || flush) pend[p] <= 1'b0;
      else if (strobe[p] && listen[p]) pend[p] <= 1'b1;
    end
  end
endmodule

// File: rtl/devs_trans_sel.sv
module devs_trans_sel
  import devs_seq_pkg::*;
#(
  parameter int NS = 4,
  parameter int NP = 2,
  parameter int SW = 2,
  parameter bit INT_FIRST = 1'b1,
  parameter logic [NS*SW-1:0]    INT_NEXT = '0,
  parameter logic [NS*NP*SW-1:0] EXT_NEXT = '0
) (
  input  logic [SW-1:0] state,
  input  logic          imm,
  input  logic          spoken,
  input  logic [NP-1:0] pend,
  input  logic          mv_grant,
  output devs_act_e     act,
  output logic [SW-1:0] next_state
);
  int  ext_port;
  logic ext_hit, int_ok;

  always_comb begin
    ext_port = 0;
    for (int p = NP - 1; p >= 0; p--) begin
      if (pend[p]) ext_port = p;
    end
    ext_hit = |pend;
    int_ok  = imm && spoken;
    act     = ACT_PASS;
    if (mv_grant) begin
      if (int_ok && (INT_FIRST || !ext_hit)) act = ACT_INT;
      else if (ext_hit)                      act = ACT_EXT;
    end
    case (act)
      ACT_INT: next_state = INT_NEXT[int'(state)*SW +: SW];
      ACT_EXT: next_state = EXT_NEXT[(int'(state)*NP + ext_port)*SW +: SW];
      default: next_state = state;
    endcase
  end
endmodule

// File: rtl/devs_atomic_seq.sv
module devs_atomic_seq
  import devs_seq_pkg::*;
#(
  parameter int NS = 4,
  parameter int NP = 2,
  parameter int TA_W = 6,
  parameter int INIT_STATE = 0,
  parameter bit INT_FIRST = 1'b1,
  parameter logic [NS*TA_W-1:0]  TA_TABLE = {6'd5, 6'd63, 6'd0, 6'd3},
  parameter logic [NS*2-1:0]     INT_NEXT = {2'd0, 2'd0, 2'd2, 2'd1},
  parameter logic [NS*NP*2-1:0]  EXT_NEXT = {2'd2, 2'd1, 2'd3, 2'd0, 2'd3, 2'd0, 2'd0, 2'd2},
  parameter logic [NS*NP-1:0]    LISTEN   = 8'b1111_1001,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] in_evt,
  input  logic          spk_grant,
  input  logic          mv_grant,
  output logic          out_evt,
  output logic          spoke,
  output logic          moved,
  output logic [SW-1:0] cur_state,
  output logic          imminent
);
  localparam logic [SW-1:0]   INIT_ST = SW'(INIT_STATE);
  localparam logic [TA_W-1:0] INIT_TA = TA_TABLE[INIT_STATE*TA_W +: TA_W];

  logic [SW-1:0] state_q, nxt;
  logic          spoken_q, imm, load;
  logic [NP-1:0] pend;
  devs_act_e     act;

  assign load = (act != ACT_PASS);

  devs_trans_sel #(
    .NS(NS), .NP(NP), .SW(SW), .INT_FIRST(INT_FIRST),
    .INT_NEXT(INT_NEXT), .EXT_NEXT(EXT_NEXT)
  ) u_sel (
    .state(state_q), .imm(imm), .spoken(spoken_q), .pend(pend),
    .mv_grant(mv_grant), .act(act), .next_state(nxt)
  );

  devs_life_timer #(.TA_W(TA_W), .INIT_TA(INIT_TA)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load),
    .load_ta(TA_TABLE[int'(nxt)*TA_W +: TA_W]), .imm(imm)
  );

  devs_port_latch #(.NP(NP)) u_ports (
    .clk(clk), .rst_n(rst_n), .flush(load), .strobe(in_evt),
    .listen(LISTEN[int'(state_q)*NP +: NP]), .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= INIT_ST;
      spoken_q <= 1'b0;
      out_evt  <= 1'b0;
      spoke    <= 1'b0;
      moved    <= 1'b0;
    end else begin
      if (load) state_q <= nxt;
      if (load)                      spoken_q <= 1'b0;
      else if (spk_grant && imm)     spoken_q <= 1'b1;
      out_evt <= spk_grant && imm && !spoken_q;
      spoke   <= spk_grant;
      moved   <= mv_grant;
    end
  end

  assign cur_state = state_q;
  assign imminent  = imm;
endmodule

// File: rtl/devs_atomic_seq_chk.sv
module devs_atomic_seq_chk #(
  parameter int NP = 2,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] in_evt,
  input logic          spk_grant,
  input logic          mv_grant,
  input logic          out_evt,
  input logic          spoke,
  input logic          moved,
  input logic [SW-1:0] cur_state,
  input logic          imminent
);
  AST_SPOKE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    spk_grant |=> spoke); // R5
  AST_MOVED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    mv_grant |=> moved); // R6
  AST_OUT_NEEDS_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    out_evt |-> $past(imminent)); // R5
  AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_evt |=> !out_evt); // R5
  AST_STATE_ONLY_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mv_grant |=> $stable(cur_state)); // R11
  AST_IMM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (imminent && !mv_grant) |=> imminent); // R11
endmodule

bind devs_atomic_seq devs_atomic_seq_chk #(.NP(NP), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_evt(in_evt), .spk_grant(spk_grant),
  .mv_grant(mv_grant), .out_evt(out_evt), .spoke(spoke), .moved(moved),
  .cur_state(cur_state), .imminent(imminent)
);

// File: tb/devs_atomic_seq_tb.sv
module devs_atomic_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] in_evt = '0, x_in = '0;
  logic spk = 1'b0, mv = 1'b0, x_spk = 1'b0, x_mv = 1'b0;
  logic out_evt, spoke, moved, imminent;
  logic x_out, x_spoke, x_moved, x_imm;
  logic [1:0] cur_state, x_state;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  devs_atomic_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_evt(in_evt), .spk_grant(spk), .mv_grant(mv),
    .out_evt(out_evt), .spoke(spoke), .moved(moved),
    .cur_state(cur_state), .imminent(imminent));

  devs_atomic_seq #(.INT_FIRST(1'b0)) dut_x (
    .clk(clk), .rst_n(rst_n), .in_evt(x_in), .spk_grant(x_spk), .mv_grant(x_mv),
    .out_evt(x_out), .spoke(x_spoke), .moved(x_moved),
    .cur_state(x_state), .imminent(x_imm));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_spk();
    spk = 1'b1; step(1); spk = 1'b0;
  endtask

  task automatic do_mv();
    mv = 1'b1; step(1); mv = 1'b0;
  endtask

  task automatic do_in(input logic [1:0] v);
    in_evt = v; step(1); in_evt = '0;
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 state", cur_state, 0);
    chk("R1 imminent", imminent, 0);
    chk("R1 acks", {out_evt, spoke, moved}, 0);
    rst_n = 1'b1;
    step(2);
    chk("R2 not yet imminent", imminent, 0);
    step(1);
    chk("R2 imminent after 3", imminent, 1);
  endtask

  task automatic t_speak();
    do_spk();
    chk("R5 spoke", spoke, 1);
    chk("R5 out_evt first", out_evt, 1);
    do_spk();
    chk("R5 spoke again", spoke, 1);
    chk("R5 no second output", out_evt, 0);
    step(1);
    chk("R5 spoke drops", spoke, 0);
  endtask

  task automatic t_internal();
    do_mv();
    chk("R6 moved", moved, 1);
    chk("R6 internal 0->1", cur_state, 1);
    chk("R3 zero lifetime", imminent, 1);
    do_mv();
    chk("R12 unspoken pass", cur_state, 1);
    chk("R12 moved", moved, 1);
  endtask

  task automatic t_conflict_int();
    do_spk();
    chk("R5 out in state1", out_evt, 1);
    do_in(2'b10);
    do_mv();
    chk("R10 internal wins", cur_state, 2);
    chk("R4 infinite not imminent", imminent, 0);
    do_mv();
    chk("R7 pending flushed", cur_state, 2);
  endtask

  task automatic t_infinite();
    step(60);
    chk("R4 still not imminent", imminent, 0);
    chk("R4 still in state2", cur_state, 2);
    do_in(2'b11);
    do_mv();
    chk("R8 lowest port 2->0", cur_state, 0);
    chk("R8 imminent clear", imminent, 0);
  endtask

  task automatic t_unlisted();
    do_in(2'b10);
    do_mv();
    chk("R9 unlisted lost", cur_state, 0);
    chk("R2 not yet", imminent, 0);
    step(1);
    chk("R2 imminent again", imminent, 1);
    step(3);
    chk("R11 imminent held", imminent, 1);
    chk("R11 state held", cur_state, 0);
  endtask

  task automatic t_ext_cancel();
    do_in(2'b01);
    do_mv();
    chk("R8 external 0->2", cur_state, 2);
    chk("R8 imminent cleared", imminent, 0);
    step(10);
    chk("R8 timer cancelled", imminent, 0);
  endtask

  task automatic t_ext_first();
    chk("R2 alt instance imminent", x_imm, 1);
    x_spk = 1'b1; step(1); x_spk = 1'b0;
    chk("R5 alt out_evt", x_out, 1);
    x_in = 2'b01; step(1); x_in = '0;
    x_mv = 1'b1; step(1); x_mv = 1'b0;
    chk("R10 external wins", x_state, 2);
    chk("R10 alt imminent clear", x_imm, 0);
  endtask

  initial begin
    step(1);
    t_reset();
    t_speak();
    t_internal();
    t_conflict_int();
    t_infinite();
    t_unlisted();
    t_ext_cancel();
    t_ext_first();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule